// File: doc/BRIEF.md
# I2C Slave Serial Port

This block is the target side of a two-wire serial bus. It watches the clock (SCL) and data (SDA) lines through synchronizers. It recognises its own address in either 7-bit or 10-bit form, with an optional per-bit mask. It shifts data bytes in and out through a single one-byte buffer that software reaches over a small register bus. The block drives both lines only by pulling them low, through the `scl_oe` and `sda_oe` outputs. It acknowledges the bytes it accepts. After every acknowledge it holds SCL low until software sets the clock release bit, which gives firmware time to read the byte it received or load the next byte to send.

Software sees four register locations: control at 0, data buffer at 1, own address (or the mask) at 2, and the two upper 10-bit address bits at 3. The control byte carries two sticky error flags: a write collision and a receive overflow. `irq` gives a one-cycle pulse for each acknowledged byte, and in the interrupt-enabled modes it also pulses for start and stop conditions.

The controller state machine has these states: `S_IDLE`, `S_RXADR` (first address byte), `S_RXADR2` (low byte of a 10-bit address), `S_RXDAT` (write data), `S_ACK` (slave pulls SDA low for the ninth clock), `S_HOLD` (clock stretch), `S_TXDAT` (read data out) and `S_TXACK` (sample the master's acknowledge). The transitions are as follows:
- A start moves any state to `S_RXADR`. A stop, or a mode that is not a slave mode, moves any state to `S_IDLE`.
- `S_RXADR`, `S_RXADR2` and `S_RXDAT` go to `S_ACK` when the byte is accepted on the eighth falling clock edge. They go to `S_IDLE` when it is refused.
- `S_ACK` goes to `S_HOLD` on the ninth falling edge.
- `S_HOLD` goes to the saved next state (`S_RXADR2`, `S_RXDAT` or `S_TXDAT`) once the release bit is 1.
- `S_TXDAT` goes to `S_TXACK` after eight bits.
- `S_TXACK` goes to `S_HOLD` on a master acknowledge, or to `S_IDLE` on a not-acknowledge.

Top module: `i2c_slave_port`

## Requirements
- R1: After reset the control byte reads 0x00 and the data buffer and own address read 0x00. The mask reads 0xFF. `scl_oe`, `sda_oe` and `irq` are 0.
- R2: The control byte is laid out as bit 7 collision flag, bit 6 overflow flag, bit 5 enable, bit 4 clock release, bits 3:0 mode. It reads back as written. While the mode is 1001, reads and writes of location 2 reach the mask. In every other mode they reach the own address.
- R3: In modes 0110 and 1110 the first byte after a start matches when ((byte[7:1] XOR addr[6:0]) AND mask[6:0]) is 0. A match is acknowledged by SDA low during the ninth clock. A miss is not acknowledged and the slave drives neither line until the next start.
- R4: A data byte written by the master while the buffer is empty is acknowledged and stored at location 1. A software read of location 1 empties the buffer.
- R5: A data byte arriving while the buffer is still full is not acknowledged. It sets control bit 6 and leaves the earlier byte in the buffer. Bit 6 stays set until software writes it to 0.
- R6: After every acknowledge the slave clears control bit 4 and holds SCL low. It lets go of SCL only after software writes bit 4 to 1.
- R7: An address byte with bit 0 set is acknowledged. After the release, the buffer is sent MSB first. A master acknowledge leads to another stretch. A master not-acknowledge leaves both lines released.
- R8: A buffer write while a byte is being shifted out sets control bit 7 and is ignored. The byte on the wire and the buffer contents stay unchanged, and bit 7 stays set until software clears it.
- R9: In modes 0111 and 1111 a first byte of 11110,A9,A8,0 is compared against location 3 bits 1:0, and the second byte is compared under the mask against location 2. A later repeated start with 11110,A9,A8,1 selects transmit. That repeated-start byte is refused when no full 10-bit match has happened since the last stop.
- R10: `irq` pulses for one cycle for each byte the slave acknowledges and for each master acknowledge of a sent byte. In modes 1110 and 1111 it also pulses on every start and stop.
- R11: When bit 5 is 0, or the mode is not one of 0110, 0111, 1110 and 1111, the slave never drives either line and acknowledges nothing. `port_en` follows bit 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of location 1 empties the buffer) |
| reg_addr | input | 2 | Register location |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| port_en | output | 1 | Lines are owned by the serial port |
| irq | output | 1 | One-cycle event pulse |

## Verification
The bench plays the bus master. It aims at these corner cases:
- A second data byte that arrives before the first is read. A design that overwrote the buffer or acknowledged the byte would report a wrong byte or a false acknowledge.
- A buffer write during a transmission. A design that accepted it would corrupt the byte on the wire.
- A 10-bit read that is attempted after a stop. A slave that kept its earlier match across the stop would answer it.
- Random masks paired with addresses that differ only in masked-out bits. A slave that ignored the mask, or applied it inverted, would acknowledge the wrong addresses.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int BYTE_W = 8;
    localparam int HI_W   = 2;

    typedef enum logic [2:0] {
        S_IDLE, S_RXADR, S_RXADR2, S_RXDAT, S_ACK, S_HOLD, S_TXDAT, S_TXACK
    } slv_state_t;

    localparam logic [3:0] MD_S7    = 4'b0110;
    localparam logic [3:0] MD_S10   = 4'b0111;
    localparam logic [3:0] MD_MSKSEL = 4'b1001;
    localparam logic [3:0] MD_S7I   = 4'b1110;
    localparam logic [3:0] MD_S10I  = 4'b1111;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_DATA = 2'd1;
    localparam logic [1:0] RA_ADDR = 2'd2;
    localparam logic [1:0] RA_AHI  = 2'd3;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pin,
    input  logic sda_pin,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] pins;
    logic [NLINES-1:0] synced;
    logic              scl_d, sda_d;

    assign pins = {sda_pin, scl_pin};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], pins[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= synced[0];
            sda_d <= synced[1];
        end
    end

    assign scl_s     = synced[0];
    assign sda_s     = synced[1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2cs_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] own_lo,
    input  logic [HI_W-1:0]   own_hi,
    input  logic [BYTE_W-1:0] mask,
    input  logic              ten_bit,
    input  logic              second,
    input  logic              hi_ok,
    output logic              hit
);
    localparam logic [4:0] TEN_TAG = 5'b11110;

    always_comb begin
        if (!ten_bit)
            hit = ((rx_byte[BYTE_W-1:1] ^ own_lo[BYTE_W-2:0]) & mask[BYTE_W-2:0]) == '0;
        else if (second)
            hit = ((rx_byte ^ own_lo) & mask) == '0;
        else
            hit = (rx_byte[7:3] == TEN_TAG) && (rx_byte[2:1] == own_hi)
                  && (!rx_byte[0] || hi_ok);
    end
endmodule

// File: rtl/i2c_slave_port.sv
module i2c_slave_port
    import i2cs_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] MASK_RST   = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        port_en,
    output logic        irq
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [3:0] mode;
    logic en_q, ckp_q, wcol_q, ov_q, buf_full, hi_ok, m_ack, irq_q, hit;
    logic [BYTE_W-1:0] buf_q, own_lo, mask_q, shreg, txsh;
    logic [HI_W-1:0]   own_hi;
    logic [CNT_W-1:0]  bitcnt;
    slv_state_t st, st_n, nxt, nxt_n;
    logic ack_evt, tx_ack_evt, hold_evt, leave_hold, store_evt, ovf_evt, hi_set, hi_clr;
    logic slave_on, ten_bit, byte_done;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_pin(scl_i), .sda_pin(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_addr_match match_i (
        .rx_byte(shreg), .own_lo(own_lo), .own_hi(own_hi), .mask(mask_q),
        .ten_bit(ten_bit), .second(st == S_RXADR2), .hi_ok(hi_ok), .hit(hit)
    );

    assign slave_on  = en_q && (mode == MD_S7 || mode == MD_S10 ||
                                mode == MD_S7I || mode == MD_S10I);
    assign ten_bit   = mode[0];
    assign byte_done = (bitcnt == CNT_W'(BYTE_W));

    // next-state logic
    always_comb begin
        st_n = st; nxt_n = nxt;
        ack_evt = 1'b0; tx_ack_evt = 1'b0; hold_evt = 1'b0; leave_hold = 1'b0;
        store_evt = 1'b0; ovf_evt = 1'b0; hi_set = 1'b0; hi_clr = 1'b0;
        if (!slave_on) begin
            st_n = S_IDLE; hi_clr = 1'b1;
        end else if (stop_det) begin
            st_n = S_IDLE; hi_clr = 1'b1;
        end else if (start_det) begin
            st_n = S_RXADR;
        end else begin
            unique case (st)
                S_IDLE: ;
                S_RXADR: if (scl_fall && byte_done) begin
                    if (hit) begin
                        st_n = S_ACK; ack_evt = 1'b1;
                        if (ten_bit && !shreg[0]) begin
                            nxt_n = S_RXADR2; hi_clr = 1'b1;
                        end else begin
                            nxt_n = shreg[0] ? S_TXDAT : S_RXDAT;
                        end
                    end else st_n = S_IDLE;
                end
                S_RXADR2: if (scl_fall && byte_done) begin
                    if (hit) begin
                        st_n = S_ACK; ack_evt = 1'b1; nxt_n = S_RXDAT; hi_set = 1'b1;
                    end else st_n = S_IDLE;
                end
                S_RXDAT: if (scl_fall && byte_done) begin
                    if (buf_full) begin
                        st_n = S_IDLE; ovf_evt = 1'b1;
                    end else begin
                        st_n = S_ACK; ack_evt = 1'b1; store_evt = 1'b1; nxt_n = S_RXDAT;
                    end
                end
                S_ACK: if (scl_fall) begin
                    st_n = S_HOLD; hold_evt = 1'b1;
                end
                S_HOLD: if (ckp_q) begin
                    st_n = nxt; leave_hold = 1'b1;
                end
                S_TXDAT: if (scl_fall && byte_done) st_n = S_TXACK;
                S_TXACK: if (scl_fall) begin
                    if (m_ack) begin
                        st_n = S_HOLD; nxt_n = S_TXDAT; hold_evt = 1'b1; tx_ack_evt = 1'b1;
                    end else st_n = S_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= S_IDLE;
            nxt <= S_IDLE;
        end else begin
            st  <= st_n;
            nxt <= nxt_n;
        end
    end

    // datapath and software registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0; en_q <= 1'b0; ckp_q <= 1'b0; wcol_q <= 1'b0; ov_q <= 1'b0;
            buf_q <= '0; own_lo <= '0; own_hi <= '0; mask_q <= MASK_RST;
            shreg <= '0; txsh <= '0; bitcnt <= '0;
            buf_full <= 1'b0; hi_ok <= 1'b0; m_ack <= 1'b0; irq_q <= 1'b0;
        end else begin
            irq_q <= ack_evt || tx_ack_evt ||
                     (slave_on && mode[3] && (start_det || stop_det));
            if (scl_rise && (st == S_RXADR || st == S_RXADR2 || st == S_RXDAT)) begin
                shreg  <= {shreg[BYTE_W-2:0], sda_s};
                bitcnt <= bitcnt + 1'b1;
            end
            if (scl_rise && st == S_TXDAT) bitcnt <= bitcnt + 1'b1;
            if (scl_fall && st == S_TXDAT && !byte_done) txsh <= {txsh[BYTE_W-2:0], 1'b0};
            if (scl_rise && st == S_TXACK) m_ack <= !sda_s;
            if (start_det || leave_hold) bitcnt <= '0;
            if (leave_hold && nxt == S_TXDAT) txsh <= buf_q;
            if (hi_clr) hi_ok <= 1'b0;
            if (hi_set) hi_ok <= 1'b1;
            if (hold_evt) ckp_q <= 1'b0;
            if (reg_rd && reg_addr == RA_DATA) buf_full <= 1'b0;
            if (reg_wr) begin
                unique case (reg_addr)
                    RA_CTRL: {wcol_q, ov_q, en_q, ckp_q, mode} <= reg_wdata;
                    RA_DATA: if (st == S_TXDAT) wcol_q <= 1'b1;
                             else               buf_q  <= reg_wdata;
                    RA_ADDR: if (mode == MD_MSKSEL) mask_q <= reg_wdata;
                             else                   own_lo <= reg_wdata;
                    RA_AHI:  own_hi <= reg_wdata[HI_W-1:0];
                endcase
            end
            if (store_evt) begin
                buf_q    <= shreg;
                buf_full <= 1'b1;
            end
            if (ovf_evt) ov_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (reg_addr)
            RA_CTRL: reg_rdata = {wcol_q, ov_q, en_q, ckp_q, mode};
            RA_DATA: reg_rdata = buf_q;
            RA_ADDR: reg_rdata = (mode == MD_MSKSEL) ? mask_q : own_lo;
            RA_AHI:  reg_rdata = {{(BYTE_W-HI_W){1'b0}}, own_hi};
        endcase
        scl_oe  = slave_on && (st == S_HOLD) && !ckp_q;
        sda_oe  = slave_on && ((st == S_ACK) || (st == S_TXDAT && !txsh[BYTE_W-1]));
        port_en = en_q;
        irq     = irq_q;
    end
endmodule

// File: rtl/i2c_slave_port_chk.sv
module i2c_slave_port_chk
    import i2cs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              slave_on,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              irq,
    input logic              ckp_q,
    input logic              ov_q,
    input logic              wcol_q,
    input logic              buf_full,
    input logic [BYTE_W-1:0] buf_q,
    input logic              reg_wr,
    input logic [1:0]        reg_addr
);
    // R11
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_on |-> (!scl_oe && !sda_oe));

    // R6
    stretch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> !ckp_q);

    // R5
    ov_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_q && !(reg_wr && reg_addr == RA_CTRL)) |=> ov_q);

    // R8
    wcol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol_q && !(reg_wr && reg_addr == RA_CTRL)) |=> wcol_q);

    // R4
    buf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !(reg_wr && reg_addr == RA_DATA)) |=> $stable(buf_q));

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

bind i2c_slave_port i2c_slave_port_chk chk_i (
    .clk(clk), .rst_n(rst_n), .slave_on(slave_on), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .irq(irq), .ckp_q(ckp_q), .ov_q(ov_q), .wcol_q(wcol_q), .buf_full(buf_full),
    .buf_q(buf_q), .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/i2c_slave_port_tb_top.sv
module i2c_slave_port_tb_top;
    localparam int PH = 12;
    localparam int WD = 180000;
    localparam logic [1:0] A_CTRL = 2'd0, A_DATA = 2'd1, A_ADDR = 2'd2, A_AHI = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic scl_oe, sda_oe, port_en, irq;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_line, sda_line;

    int ntests = 0, nfail = 0, irq_cnt = 0;
    bit drv_seen = 1'b0, done = 1'b0;

    always #10 clk = ~clk;

    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);

    i2c_slave_port dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .port_en(port_en), .irq(irq)
    );

    always @(posedge clk) begin
        if (irq) irq_cnt <= irq_cnt + 1;
        if (scl_oe || sda_oe) drv_seen <= 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit exp_hit7(input logic [7:0] rx, input logic [6:0] own, input logic [7:0] msk);
        return (((rx[7:1] ^ own) & msk[6:0]) == 7'd0);
    endfunction

    task automatic ph();
        repeat (PH) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic scl_up();
        m_scl_low = 1'b0;
        while (!scl_line) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda_low = 1'b0; ph();
        scl_up(); ph();
        m_sda_low = 1'b1; ph();
        m_scl_low = 1'b1; ph();
    endtask

    task automatic i2c_stop();
        m_sda_low = 1'b1; ph();
        scl_up(); ph();
        m_sda_low = 1'b0; ph();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !b[i]; ph();
            scl_up(); ph();
            m_scl_low = 1'b1;
        end
        m_sda_low = 1'b0; ph();
        scl_up();
        repeat (PH/2) @(negedge clk);
        ack = !sda_line;
        repeat (PH/2) @(negedge clk);
        m_scl_low = 1'b1; ph();
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            ph();
            scl_up();
            repeat (PH/2) @(negedge clk);
            b[i] = sda_line;
            repeat (PH/2) @(negedge clk);
            m_scl_low = 1'b1;
        end
        m_sda_low = mack; ph();
        scl_up(); ph();
        m_scl_low = 1'b1; m_sda_low = 1'b0; ph();
    endtask

    task automatic release_clk();
        logic [7:0] c;
        reg_read(A_CTRL, c);
        reg_write(A_CTRL, c | 8'h10);
        repeat (4) @(negedge clk);
    endtask

    task automatic set_mask(input logic [7:0] m, input logic [7:0] ctrl_after);
        reg_write(A_CTRL, 8'h09);
        reg_write(A_ADDR, m);
        reg_write(A_CTRL, ctrl_after);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, d;
        bit ack;
        int base;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        reg_read(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
        reg_read(A_DATA, v); chk("R1 data", v, 8'h00);
        reg_read(A_ADDR, v); chk("R1 addr", v, 8'h00);
        chk("R1 lines", {scl_oe, sda_oe, irq}, 3'b000);
        reg_write(A_CTRL, 8'h09);
        reg_read(A_ADDR, v); chk("R1 mask", v, 8'hFF);

        // R2 layout and mask redirect
        reg_write(A_ADDR, 8'hF0);
        reg_write(A_CTRL, 8'h26);
        reg_read(A_CTRL, v); chk("R2 ctrl readback", v, 8'h26);
        reg_write(A_ADDR, 8'h2A);
        reg_read(A_ADDR, v); chk("R2 addr", v, 8'h2A);
        reg_write(A_CTRL, 8'h09);
        reg_read(A_ADDR, v); chk("R2 mask", v, 8'hF0);
        reg_write(A_ADDR, 8'hFF);
        reg_write(A_CTRL, 8'h26);
        chk("R11 port_en on", port_en, 1'b1);

        // R3 R4 R6 R10 directed write
        base = irq_cnt;
        i2c_start();
        send_byte(8'h54, ack); chk("R3 match ack", ack, 1'b1);
        chk("R6 stretch", scl_oe, 1'b1);
        reg_read(A_CTRL, v); chk("R6 release cleared", v[4], 1'b0);
        release_clk(); chk("R6 let go", scl_oe, 1'b0);
        send_byte(8'hA5, ack); chk("R4 data ack", ack, 1'b1);
        reg_read(A_DATA, v); chk("R4 buffer", v, 8'hA5);
        release_clk();
        i2c_stop(); ph();
        chk("R10 irq count plain mode", irq_cnt - base, 2);

        // R3 miss
        drv_seen = 1'b0;
        i2c_start();
        send_byte(8'h56, ack); chk("R3 miss nack", ack, 1'b0);
        i2c_stop(); ph();
        chk("R3 miss no drive", drv_seen, 1'b0);

        // R5 overflow
        i2c_start();
        send_byte(8'h54, ack); release_clk();
        send_byte(8'h11, ack); chk("R5 first ack", ack, 1'b1);
        release_clk();
        send_byte(8'h22, ack); chk("R5 overflow nack", ack, 1'b0);
        i2c_stop(); ph();
        reg_read(A_CTRL, v); chk("R5 flag set", v[6], 1'b1);
        reg_read(A_DATA, v); chk("R5 old byte kept", v, 8'h11);
        reg_read(A_CTRL, v); chk("R5 flag sticky", v[6], 1'b1);
        reg_write(A_CTRL, 8'h26);
        reg_read(A_CTRL, v); chk("R5 flag cleared", v[6], 1'b0);

        // R7 R8 transmit and collision
        reg_write(A_DATA, 8'h3C);
        i2c_start();
        send_byte(8'h55, ack); chk("R7 read addr ack", ack, 1'b1);
        chk("R7 stretch before send", scl_oe, 1'b1);
        release_clk();
        recv_byte(1'b1, d); chk("R7 byte0", d, 8'h3C);
        chk("R7 stretch after master ack", scl_oe, 1'b1);
        reg_write(A_DATA, 8'hC3);
        release_clk();
        reg_write(A_DATA, 8'h99);
        reg_read(A_CTRL, v); chk("R8 collision flag", v[7], 1'b1);
        recv_byte(1'b0, d); chk("R8 wire byte intact", d, 8'hC3);
        reg_read(A_DATA, v); chk("R8 write ignored", v, 8'hC3);
        chk("R7 lines free after nack", {scl_oe, sda_oe}, 2'b00);
        i2c_stop(); ph();
        reg_read(A_CTRL, v); chk("R8 flag sticky", v[7], 1'b1);
        reg_write(A_CTRL, 8'h26);

        // R10 start/stop interrupts
        reg_write(A_CTRL, 8'h2E);
        base = irq_cnt;
        i2c_start();
        send_byte(8'h54, ack); release_clk();
        send_byte(8'h5A, ack); reg_read(A_DATA, v); release_clk();
        i2c_stop(); ph();
        chk("R10 irq count with start/stop", irq_cnt - base, 4);

        // R9 ten-bit
        set_mask(8'hFF, 8'h27);
        reg_write(A_ADDR, 8'h5B);
        reg_write(A_AHI, 8'h02);
        i2c_start();
        send_byte(8'hF4, ack); chk("R9 high byte ack", ack, 1'b1); release_clk();
        send_byte(8'h5B, ack); chk("R9 low byte ack", ack, 1'b1); release_clk();
        send_byte(8'h77, ack); chk("R9 data ack", ack, 1'b1);
        reg_read(A_DATA, v); chk("R9 data", v, 8'h77); release_clk();
        i2c_start();
        send_byte(8'hF5, ack); chk("R9 restart read ack", ack, 1'b1);
        reg_write(A_DATA, 8'h81); release_clk();
        recv_byte(1'b0, d); chk("R9 read byte", d, 8'h81);
        i2c_stop(); ph();
        i2c_start();
        send_byte(8'hF5, ack); chk("R9 read after stop refused", ack, 1'b0);
        i2c_stop(); ph();
        i2c_start();
        send_byte(8'hF2, ack); chk("R9 wrong high bits", ack, 1'b0);
        i2c_stop(); ph();

        // R11 disabled and non-slave mode
        reg_write(A_CTRL, 8'h06);
        chk("R11 port_en off", port_en, 1'b0);
        drv_seen = 1'b0;
        i2c_start(); send_byte(8'h54, ack); i2c_stop(); ph();
        chk("R11 disabled nack", ack, 1'b0);
        reg_write(A_CTRL, 8'h2B);
        i2c_start(); send_byte(8'h54, ack); i2c_stop(); ph();
        chk("R11 firmware mode nack", ack, 1'b0);
        chk("R11 never drove", drv_seen, 1'b0);

        // R3 R4 random addresses and masks
        for (int it = 0; it < 16; it++) begin
            logic [7:0] msk, rx, dat;
            logic [6:0] own;
            bit e;
            msk = 8'($urandom);
            own = 7'($urandom);
            if ($urandom % 2) rx = {own ^ (7'($urandom) & ~msk[6:0]), 1'b0};
            else              rx = {7'($urandom), 1'b0};
            e = exp_hit7(rx, own, msk);
            set_mask(msk, 8'h26);
            reg_write(A_ADDR, {1'b0, own});
            i2c_start();
            send_byte(rx, ack); chk("R3 random match", ack, e);
            if (e) begin
                release_clk();
                dat = 8'($urandom);
                send_byte(dat, ack); chk("R4 random data ack", ack, 1'b1);
                reg_read(A_DATA, v); chk("R4 random data", v, dat);
                release_clk();
            end
            i2c_stop(); ph();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule